// File: doc/BRIEF.md
# Vector-Clock Happens-Before Checker

This unit evaluates one memory or synchronization event against vector clocks that hold one logical clock per core. Every lane is compared and merged in parallel. A read or write event is checked for a data race against the last-write and last-reads history of a location. The history vectors are then advanced by the access rules. Every accepted event also grades the permission the current thread holds on that location.

Synchronization events use the same lane hardware. An acquire merges a lock clock into the thread clock. A release hands back the captured thread clock as the new lock clock and then advances the thread's own lane. An initialise event produces a fresh thread clock and empty access history.

A caller presents the thread clock, the two history vectors, a lock clock, the thread's lane index and an operation code with a valid strobe. One cycle later the registered results come back with a done pulse. Lock storage, history persistence and memory access belong to the surrounding system.

Top module: `vc_hb_unit`

## Requirements
- R1: Vector A happens before vector B only when every lane of A is less than or equal to the same lane of B; equal lanes count as ordered.
- R2: A read event (op 1) flags a race exactly when the last-write vector does not happen before the thread clock. On a race, all returned vectors equal their inputs.
- R3: A race-free read returns the last-reads vector with the reader's lane replaced by the thread's own lane value. All other lanes, and the thread and last-write vectors, pass through unchanged.
- R4: A write event (op 2) flags a race when either the last-write vector or the last-reads vector fails to happen before the thread clock. On a race, all returned vectors equal their inputs.
- R5: A race-free write returns an all-zero last-reads vector. The returned last-write vector is zero in every lane except the writer's, which holds the writer's own lane value.
- R6: For every event, the permission output is computed from the input vectors. It is 2 (write) when both history vectors happen before the thread clock, 1 (read) when only the last-write vector does, and 0 (none) otherwise.
- R7: An acquire (op 4) returns as thread clock the lane-wise maximum of the thread clock and the lock clock.
- R8: A release (op 5) returns the input thread clock as the new lock clock. It returns the thread clock with the thread's own lane incremented by one, modulo 2^CW.
- R9: An initialise event (op 0) returns a thread clock with the thread's own lane at 1 and all others at 0, and all-zero last-write and last-reads vectors.
- R10: The unit is always ready. An event accepted on a rising edge raises done for exactly the next cycle. The outputs keep their values while no event is accepted.
- R11: Permission queries (op 3), unused codes (6, 7), acquire, release and initialise never flag a race. Permission queries and unused codes return all vectors unchanged.
- R12: During and after reset, before the first event, done and race are 0, the permission is 0 and all output vectors are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Event presented this cycle |
| in_ready | output | 1 | Unit can accept an event (always 1) |
| op_i | input | 3 | Event code: 0 init, 1 read, 2 write, 3 permission query, 4 acquire, 5 release |
| tid_i | input | TW | Lane index of the acting thread |
| thr_vc_i | input | LANES*CW | Thread vector clock, lane k at bits [k*CW +: CW] |
| wr_vc_i | input | LANES*CW | Last-write vector of the location |
| rd_vc_i | input | LANES*CW | Last-reads vector of the location |
| lock_vc_i | input | LANES*CW | Lock vector clock (acquire operand) |
| done_o | output | 1 | One-cycle pulse, results valid |
| race_o | output | 1 | Race found by the event |
| perm_o | output | 2 | Permission grade: 2 write, 1 read, 0 none |
| thr_vc_o | output | LANES*CW | Updated thread vector clock |
| wr_vc_o | output | LANES*CW | Updated last-write vector |
| rd_vc_o | output | LANES*CW | Updated last-reads vector |
| lock_vc_o | output | LANES*CW | Updated lock vector clock |

## Verification
The bench builds the unit with four lanes of eight bits. Every vector then fits in one 32-bit hex word, each lane in two digits, so per-lane effects are easy to read. The narrow lane makes the modulo wrap of the release increment reachable with a lane value of 255. It also lets an all-ones thread clock against an all-ones last-write vector test the equal-lanes ordering boundary. With four lanes, each of the one-hot own-lane updates can be placed at the low end, in the middle and at the top of the vector.

// File: rtl/vc_pkg.sv
package vc_pkg;

  typedef enum logic [2:0] {
    OP_INIT    = 3'd0,
    OP_READ    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_PERM    = 3'd3,
    OP_ACQUIRE = 3'd4,
    OP_RELEASE = 3'd5
  } vc_op_e;

  typedef enum logic [1:0] {
    PERM_NONE  = 2'd0,
    PERM_READ  = 2'd1,
    PERM_WRITE = 2'd2
  } vc_perm_e;

endpackage

// File: rtl/vc_lane_ops.sv
module vc_lane_ops #(
  parameter int LANES = 8,
  parameter int CW    = 64,
  localparam int TW   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int VW   = LANES * CW
) (
  input  logic [TW-1:0]    tid_i,
  input  logic [VW-1:0]    thr_i,
  input  logic [VW-1:0]    wr_i,
  input  logic [VW-1:0]    rd_i,
  input  logic [VW-1:0]    lock_i,
  output logic [VW-1:0]    max_o,
  output logic [VW-1:0]    rd_upd_o,
  output logic [VW-1:0]    wr_upd_o,
  output logic [VW-1:0]    rel_thr_o,
  output logic [VW-1:0]    init_thr_o,
  output logic [LANES-1:0] wr_le_o,
  output logic [LANES-1:0] rd_le_o
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [CW-1:0] thr_l, wr_l, rd_l, lock_l;
    logic          own;

    assign thr_l  = thr_i[k*CW +: CW];
    assign wr_l   = wr_i[k*CW +: CW];
    assign rd_l   = rd_i[k*CW +: CW];
    assign lock_l = lock_i[k*CW +: CW];
    assign own    = (tid_i == TW'(k));

    always_comb begin
      max_o[k*CW +: CW]      = (lock_l > thr_l) ? lock_l : thr_l;
      wr_le_o[k]             = (wr_l <= thr_l);
      rd_le_o[k]             = (rd_l <= thr_l);
      rd_upd_o[k*CW +: CW]   = own ? thr_l : rd_l;
      wr_upd_o[k*CW +: CW]   = own ? thr_l : '0;
      rel_thr_o[k*CW +: CW]  = own ? (thr_l + ONE) : thr_l;
      init_thr_o[k*CW +: CW] = own ? ONE : '0;
    end

    always_comb begin
      if (!own) begin
        AST_OTHER_LANE_KEEPS: assert (rd_upd_o[k*CW +: CW] == rd_l); // R3
      end
    end
  end

endmodule

// File: rtl/vc_hb_reduce.sv
module vc_hb_reduce #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] le_i,
  output logic             hb_o
);

  logic [LANES:0] chain;

  assign chain[0] = 1'b1;
  for (genvar k = 0; k < LANES; k++) begin : g_and
    assign chain[k+1] = chain[k] & le_i[k];
  end
  assign hb_o = chain[LANES];

  always_comb begin
    if (hb_o) begin
      AST_HB_ALL_LANES: assert (le_i == '1); // R1
    end
  end

endmodule

// File: rtl/vc_decide.sv
module vc_decide
  import vc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CW    = 64,
  localparam int VW   = LANES * CW
) (
  input  logic [2:0]    op_i,
  input  logic          wr_hb_i,
  input  logic          rd_hb_i,
  input  logic [VW-1:0] thr_i,
  input  logic [VW-1:0] wr_i,
  input  logic [VW-1:0] rd_i,
  input  logic [VW-1:0] lock_i,
  input  logic [VW-1:0] max_i,
  input  logic [VW-1:0] rd_upd_i,
  input  logic [VW-1:0] wr_upd_i,
  input  logic [VW-1:0] rel_thr_i,
  input  logic [VW-1:0] init_thr_i,
  output logic          race_o,
  output logic [1:0]    perm_o,
  output logic [VW-1:0] thr_o,
  output logic [VW-1:0] wr_o,
  output logic [VW-1:0] rd_o,
  output logic [VW-1:0] lock_o
);

  always_comb begin
    if (wr_hb_i && rd_hb_i) perm_o = PERM_WRITE;
    else if (wr_hb_i)       perm_o = PERM_READ;
    else                    perm_o = PERM_NONE;
  end

  always_comb begin
    race_o = 1'b0;
    thr_o  = thr_i;
    wr_o   = wr_i;
    rd_o   = rd_i;
    lock_o = lock_i;
    case (op_i)
      OP_INIT: begin
        thr_o = init_thr_i;
        wr_o  = '0;
        rd_o  = '0;
      end
      OP_READ: begin
        race_o = !wr_hb_i;
        if (wr_hb_i) rd_o = rd_upd_i;
      end
      OP_WRITE: begin
        race_o = !(wr_hb_i && rd_hb_i);
        if (wr_hb_i && rd_hb_i) begin
          wr_o = wr_upd_i;
          rd_o = '0;
        end
      end
      OP_ACQUIRE: thr_o = max_i;
      OP_RELEASE: begin
        lock_o = thr_i;
        thr_o  = rel_thr_i;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (op_i == OP_WRITE && perm_o == PERM_WRITE) begin
      AST_WRITE_PERM_NO_RACE: assert (!race_o); // R4
    end
    if (op_i == OP_READ && perm_o != PERM_NONE) begin
      AST_READ_PERM_NO_RACE: assert (!race_o); // R2
    end
  end

endmodule

// File: rtl/vc_hb_unit.sv
module vc_hb_unit
  import vc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CW    = 64,
  localparam int TW   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int VW   = LANES * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    op_i,
  input  logic [TW-1:0] tid_i,
  input  logic [VW-1:0] thr_vc_i,
  input  logic [VW-1:0] wr_vc_i,
  input  logic [VW-1:0] rd_vc_i,
  input  logic [VW-1:0] lock_vc_i,
  output logic          done_o,
  output logic          race_o,
  output logic [1:0]    perm_o,
  output logic [VW-1:0] thr_vc_o,
  output logic [VW-1:0] wr_vc_o,
  output logic [VW-1:0] rd_vc_o,
  output logic [VW-1:0] lock_vc_o
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  assign in_ready = 1'b1;

  logic             accept;
  logic [VW-1:0]    max_w, rd_upd_w, wr_upd_w, rel_thr_w, init_thr_w;
  logic [LANES-1:0] wr_le_w, rd_le_w;
  logic             wr_hb_w, rd_hb_w;
  logic             race_d;
  logic [1:0]       perm_d;
  logic [VW-1:0]    thr_d, wr_d, rd_d, lock_d;

  assign accept = in_valid & in_ready;

  vc_lane_ops #(.LANES(LANES), .CW(CW)) u_lanes (
    .tid_i      (tid_i),
    .thr_i      (thr_vc_i),
    .wr_i       (wr_vc_i),
    .rd_i       (rd_vc_i),
    .lock_i     (lock_vc_i),
    .max_o      (max_w),
    .rd_upd_o   (rd_upd_w),
    .wr_upd_o   (wr_upd_w),
    .rel_thr_o  (rel_thr_w),
    .init_thr_o (init_thr_w),
    .wr_le_o    (wr_le_w),
    .rd_le_o    (rd_le_w)
  );

  vc_hb_reduce #(.LANES(LANES)) u_wr_hb (.le_i(wr_le_w), .hb_o(wr_hb_w));
  vc_hb_reduce #(.LANES(LANES)) u_rd_hb (.le_i(rd_le_w), .hb_o(rd_hb_w));

  vc_decide #(.LANES(LANES), .CW(CW)) u_decide (
    .op_i       (op_i),
    .wr_hb_i    (wr_hb_w),
    .rd_hb_i    (rd_hb_w),
    .thr_i      (thr_vc_i),
    .wr_i       (wr_vc_i),
    .rd_i       (rd_vc_i),
    .lock_i     (lock_vc_i),
    .max_i      (max_w),
    .rd_upd_i   (rd_upd_w),
    .wr_upd_i   (wr_upd_w),
    .rel_thr_i  (rel_thr_w),
    .init_thr_i (init_thr_w),
    .race_o     (race_d),
    .perm_o     (perm_d),
    .thr_o      (thr_d),
    .wr_o       (wr_d),
    .rd_o       (rd_d),
    .lock_o     (lock_d)
  );

  // next-state
  logic          done_n, race_n;
  logic [1:0]    perm_n;
  logic [VW-1:0] thr_n, wr_n, rd_n, lock_n;

  always_comb begin
    done_n = accept;
    race_n = race_o;
    perm_n = perm_o;
    thr_n  = thr_vc_o;
    wr_n   = wr_vc_o;
    rd_n   = rd_vc_o;
    lock_n = lock_vc_o;
    if (accept) begin
      race_n = race_d;
      perm_n = perm_d;
      thr_n  = thr_d;
      wr_n   = wr_d;
      rd_n   = rd_d;
      lock_n = lock_d;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done_o    <= 1'b0;
      race_o    <= 1'b0;
      perm_o    <= 2'd0;
      thr_vc_o  <= '0;
      wr_vc_o   <= '0;
      rd_vc_o   <= '0;
      lock_vc_o <= '0;
    end else begin
      done_o    <= done_n;
      race_o    <= race_n;
      perm_o    <= perm_n;
      thr_vc_o  <= thr_n;
      wr_vc_o   <= wr_n;
      rd_vc_o   <= rd_n;
      lock_vc_o <= lock_n;
    end
  end

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> done_o); // R10
  AST_DONE_ONLY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !done_o); // R10
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> $stable(thr_vc_o) && $stable(rd_vc_o) && $stable(wr_vc_o)); // R10
  AST_WRITE_CLEARS_READS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && op_i == OP_WRITE |=> race_o || rd_vc_o == '0); // R5
  AST_READ_RACE_KEEPS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && op_i == OP_READ |=> !race_o || rd_vc_o == $past(rd_vc_i)); // R2
  AST_SYNC_NO_RACE: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && (op_i == OP_ACQUIRE || op_i == OP_RELEASE || op_i == OP_PERM) |=> !race_o); // R11
  AST_PERM_LEGAL: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o |-> perm_o != 2'd3); // R6

endmodule

// File: tb/vc_hb_unit_bench.sv
module vc_hb_unit_bench;

  localparam int LANES = 4;
  localparam int CW    = 8;
  localparam int TW    = 2;
  localparam int VW    = 32;

  typedef struct packed {
    logic [3:0]    req;
    logic [2:0]    op;
    logic [TW-1:0] tid;
    logic [VW-1:0] thr;
    logic [VW-1:0] wr;
    logic [VW-1:0] rd;
    logic [VW-1:0] lock;
    logic          e_race;
    logic [1:0]    e_perm;
    logic [VW-1:0] e_thr;
    logic [VW-1:0] e_wr;
    logic [VW-1:0] e_rd;
    logic [VW-1:0] e_lock;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    // R3 race-free read, reader lane 0 takes 5; perm read
    '{4'd3, 3'd1, 2'd0, 32'h01020305, 32'h00000300, 32'h07000000, 32'h0,
      1'b0, 2'd1, 32'h01020305, 32'h00000300, 32'h07000005, 32'h0},
    // R2 read with unordered write in lane 1
    '{4'd2, 3'd1, 2'd1, 32'h01020305, 32'h00000400, 32'h00000900, 32'h0,
      1'b1, 2'd0, 32'h01020305, 32'h00000400, 32'h00000900, 32'h0},
    // R5 race-free write by lane 2
    '{4'd5, 3'd2, 2'd2, 32'h01020305, 32'h00010000, 32'h00000305, 32'h0,
      1'b0, 2'd2, 32'h01020305, 32'h00020000, 32'h00000000, 32'h0},
    // R4 write racing with a read in lane 0
    '{4'd4, 3'd2, 2'd0, 32'h01020305, 32'h00000000, 32'h00000306, 32'h0,
      1'b1, 2'd1, 32'h01020305, 32'h00000000, 32'h00000306, 32'h0},
    // R4 write racing with a write in lane 0
    '{4'd4, 3'd2, 2'd0, 32'h01020305, 32'h00000006, 32'h00000000, 32'h0,
      1'b1, 2'd0, 32'h01020305, 32'h00000006, 32'h00000000, 32'h0},
    // R7 acquire merges lock clock lane-wise
    '{4'd7, 3'd4, 2'd0, 32'h01020305, 32'h0, 32'h0, 32'h03000702,
      1'b0, 2'd2, 32'h03020705, 32'h0, 32'h0, 32'h03000702},
    // R8 release by lane 3
    '{4'd8, 3'd5, 2'd3, 32'h01020305, 32'h0, 32'h0, 32'h0,
      1'b0, 2'd2, 32'h02020305, 32'h0, 32'h0, 32'h01020305},
    // R8 release wraps lane 1 from 255 to 0
    '{4'd8, 3'd5, 2'd1, 32'h0000FF00, 32'h0, 32'h0, 32'h0,
      1'b0, 2'd2, 32'h00000000, 32'h0, 32'h0, 32'h0000FF00},
    // R9 init for lane 2; perm from inputs is none (R6)
    '{4'd9, 3'd0, 2'd2, 32'h11223344, 32'h00000055, 32'h00000066, 32'h0,
      1'b0, 2'd0, 32'h00010000, 32'h0, 32'h0, 32'h0},
    // R11 permission query, write grade, vectors unchanged
    '{4'd11, 3'd3, 2'd0, 32'h01020305, 32'h00000300, 32'h00000005, 32'h0,
      1'b0, 2'd2, 32'h01020305, 32'h00000300, 32'h00000005, 32'h0},
    // R11 unused code 7 acts as a query; R6 grade none
    '{4'd11, 3'd7, 2'd0, 32'h01020305, 32'h02000000, 32'h0, 32'h0,
      1'b0, 2'd0, 32'h01020305, 32'h02000000, 32'h0, 32'h0},
    // R1 equal lanes count as ordered
    '{4'd1, 3'd1, 2'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0,
      1'b0, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFF000000, 32'h0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [2:0]    op_i;
  logic [TW-1:0] tid_i;
  logic [VW-1:0] thr_vc_i, wr_vc_i, rd_vc_i, lock_vc_i;
  logic          done_o, race_o;
  logic [1:0]    perm_o;
  logic [VW-1:0] thr_vc_o, wr_vc_o, rd_vc_o, lock_vc_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  vc_hb_unit #(.LANES(LANES), .CW(CW)) u_vc_hb_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_i(op_i), .tid_i(tid_i), .thr_vc_i(thr_vc_i), .wr_vc_i(wr_vc_i),
    .rd_vc_i(rd_vc_i), .lock_vc_i(lock_vc_i), .done_o(done_o), .race_o(race_o),
    .perm_o(perm_o), .thr_vc_o(thr_vc_o), .wr_vc_o(wr_vc_o), .rd_vc_o(rd_vc_o),
    .lock_vc_o(lock_vc_o)
  );

  task automatic check(input string tag, input logic [163:0] act, input logic [163:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [163:0] outs();
    return {done_o, race_o, perm_o, thr_vc_o, wr_vc_o, rd_vc_o, lock_vc_o, 32'h0};
  endfunction

  initial begin
    #100000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_i = 3'd3; tid_i = '0;
    thr_vc_i = '0; wr_vc_i = '0; rd_vc_i = '0; lock_vc_i = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset", outs(), 164'h0);
    check("R10 ready", {163'h0, in_ready}, {163'h0, 1'b1});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 after release", outs(), 164'h0);

    for (int i = 0; i < NV; i++) begin
      in_valid  = 1'b1;
      op_i      = TBL[i].op;
      tid_i     = TBL[i].tid;
      thr_vc_i  = TBL[i].thr;
      wr_vc_i   = TBL[i].wr;
      rd_vc_i   = TBL[i].rd;
      lock_vc_i = TBL[i].lock;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vector %0d", TBL[i].req, i), outs(),
            {1'b1, TBL[i].e_race, TBL[i].e_perm, TBL[i].e_thr, TBL[i].e_wr,
             TBL[i].e_rd, TBL[i].e_lock, 32'h0});
      @(negedge clk);
    end

    // R10 done lasts one cycle and outputs hold while idle
    in_valid = 1'b1; op_i = 3'd1; tid_i = 2'd2;
    thr_vc_i = 32'h00050000; wr_vc_i = 32'h0; rd_vc_i = 32'h01000000; lock_vc_i = 32'h0;
    @(negedge clk);
    in_valid = 1'b0;
    thr_vc_i = 32'hAAAAAAAA; rd_vc_i = 32'h12345678;
    check("R10 done pulse", outs(),
          {1'b1, 1'b0, 2'd1, 32'h00050000, 32'h0, 32'h01050000, 32'h0, 32'h0});
    @(negedge clk);
    check("R10 idle hold", outs(),
          {1'b0, 1'b0, 2'd1, 32'h00050000, 32'h0, 32'h01050000, 32'h0, 32'h0});

    // R10 back-to-back events, done stays high
    in_valid = 1'b1; op_i = 3'd0; tid_i = 2'd0;
    @(negedge clk);
    check("R10 b2b first", {163'h0, done_o}, {163'h0, 1'b1});
    op_i = 3'd5; thr_vc_i = 32'h00000001; tid_i = 2'd0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 b2b release", {done_o, thr_vc_o, lock_vc_o},
          {1'b1, 32'h00000002, 32'h00000001});
    @(negedge clk);

    // R12 reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 reset again", outs(), 164'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule